// File: doc/BRIEF.md
# Push-Button Three-Cycle Pulse Controller

This block turns the level of a push-button into a fixed three-cycle output. The raw button is first brought into the clock domain by a short flip-flop chain. A three-state conditioner then reduces each press to a single one-cycle pulse, however long the button is held. That pulse triggers a four-state timer, which holds the output high for exactly three clock cycles.

While the timer is running it ignores further trigger pulses, so pressing again or holding the button cannot lengthen or restart the output. The conditioner only arms for a new press after it has seen the button released. The one-cycle press pulse is brought out as a debug port.

Top module: `btn_pulse_ctrl`

## Requirements
- R1: While `rst_ni` is low, both state machines are held in their idle states and `press_o` and `active_o` are 0. This takes effect at once, without waiting for a clock edge.
- R2: The button passes through `SYNC_STAGES` flip-flops (default 2) before the conditioner. With the default, a button sampled high at clock edge k gives a `press_o` pulse after edge k+2.
- R3: Each press gives a `press_o` pulse exactly one cycle long, however many cycles the button stays high.
- R4: After a pulse, no new pulse is given until the synchronized button has been seen low. A button held high for many cycles gives only one pulse.
- R5: A press held for a single clock edge still gives a full one-cycle pulse.
- R6: A `press_o` pulse seen by an idle timer makes `active_o` go high after the next clock edge.
- R7: `active_o` stays high for exactly three cycles and then goes low. The timer states are encoded idle=00, first=01, second=10, third=11, and `active_o` is the OR of the two state bits.
- R8: A `press_o` pulse that arrives while `active_o` is high is ignored, and the high run is not extended. This includes a pulse during the third high cycle.
- R9: A pulse that arrives in the first cycle after the timer returns to idle starts a new three-cycle run at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| button_i | input | 1 | Raw button level, asynchronous to the clock |
| press_o | output | 1 | One-cycle press pulse (debug) |
| active_o | output | 1 | Output held high for three cycles per accepted press |

## Verification
The assertions check the per-cycle rules on every cycle:
- the press pulse never lasts two cycles, and a held button keeps the conditioner armed-off;
- an idle timer accepts a trigger on the next edge;
- the timer walks its three high states in order and never restarts while busy;
- the output rises only after a press pulse that followed a button level three edges earlier.

Only the bench's scenarios can show the whole cycle-exact trace of an end-to-end press. They cover a single-cycle press, a long hold, a quick double press, and presses landing in the last busy cycle and just after it. They also show an asynchronous reset cutting a running output.

// File: rtl/btn_pulse_pkg.sv
package btn_pulse_pkg;

  typedef enum logic [1:0] {
    COND_IDLE = 2'b00,
    COND_FIRE = 2'b01,
    COND_HOLD = 2'b10
  } cond_state_e;

  // encoding fixed: output is OR of the two state bits
  typedef enum logic [1:0] {
    TMR_OFF = 2'b00,
    TMR_ON1 = 2'b01,
    TMR_ON2 = 2'b10,
    TMR_ON3 = 2'b11
  } tmr_state_e;

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  localparam int unsigned N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0] chain_q;

  generate
    for (genvar g = 0; g < N; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[N-1];
endmodule

// File: rtl/press_cond_fsm.sv
module press_cond_fsm
  import btn_pulse_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  cond_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      COND_IDLE: if (level_i) state_d = COND_FIRE;
      COND_FIRE: state_d = level_i ? COND_HOLD : COND_IDLE;
      COND_HOLD: if (!level_i) state_d = COND_IDLE;
      default:   state_d = COND_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= COND_IDLE;
    else         state_q <= state_d;
  end

  assign pulse_o = (state_q == COND_FIRE);

  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  p_held_no_rearm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == COND_HOLD && level_i) |=> (state_q == COND_HOLD && !pulse_o));

  p_fire_from_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> ($past(state_q) == COND_IDLE));
endmodule

// File: rtl/pulse_timer_fsm.sv
module pulse_timer_fsm
  import btn_pulse_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  tmr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TMR_OFF: if (trig_i) state_d = TMR_ON1;
      TMR_ON1: state_d = TMR_ON2;
      TMR_ON2: state_d = TMR_ON3;
      TMR_ON3: state_d = TMR_OFF;
      default: state_d = TMR_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TMR_OFF;
    else         state_q <= state_d;
  end

  assign active_o = state_q[1] | state_q[0];

  p_start_on_trig_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TMR_OFF && trig_i) |=> (state_q == TMR_ON1));

  p_on1_to_on2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TMR_ON1) |=> (state_q == TMR_ON2));

  p_on2_to_on3_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TMR_ON2) |=> (state_q == TMR_ON3));

  p_on3_to_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TMR_ON3) |=> (state_q == TMR_OFF));

  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != TMR_OFF) |=> (state_q != TMR_ON1));
endmodule

// File: rtl/btn_pulse_ctrl.sv
module btn_pulse_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic button_i,
  output logic press_o,
  output logic active_o
);
  logic btn_sync;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (button_i),
    .sync_o  (btn_sync)
  );

  press_cond_fsm u_cond (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (btn_sync),
    .pulse_o (press_o)
  );

  pulse_timer_fsm u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (press_o),
    .active_o (active_o)
  );

  p_rise_after_press_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(press_o));

  // default chain depth only: press rise traces back to the button three edges earlier
  if (SYNC_STAGES == 2) begin : g_lat_chk
    p_press_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(press_o) |-> $past(button_i, 3));
  end
endmodule

// File: tb/btn_pulse_ctrl_bench.sv
module btn_pulse_ctrl_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic button_i = 1'b0;
  logic press_o, active_o;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  btn_pulse_ctrl u_btn_pulse_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .button_i (button_i),
    .press_o  (press_o),
    .active_o (active_o)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    button_i = 1'b0;
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // bit k of pat: button level at edge k; traces record outputs after edge k
  task automatic run_pat(logic [31:0] pat, int n,
                         output logic [31:0] pr, output logic [31:0] xr);
    pr = '0; xr = '0;
    for (int k = 1; k <= n; k++) begin
      button_i = pat[k];
      @(posedge clk); #1;
      pr[k] = press_o;
      xr[k] = active_o;
    end
    idle(6);
  endtask

  task automatic t_reset();
    check("R1 press in reset", {31'b0, press_o}, 32'h0);
    check("R1 active in reset", {31'b0, active_o}, 32'h0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    idle(3);
  endtask

  task automatic t_short_press();
    logic [31:0] pr, xr;
    run_pat(32'h2, 12, pr, xr);
    check("R2 R5 short press pulse", pr, 32'h8);
    check("R6 R7 short press run", xr, 32'h70);
  endtask

  task automatic t_long_hold();
    logic [31:0] pr, xr;
    run_pat(32'h7FE, 16, pr, xr);
    check("R3 R4 long hold pulse", pr, 32'h8);
    check("R7 long hold run", xr, 32'h70);
  endtask

  task automatic t_double_press();
    logic [31:0] pr, xr;
    run_pat(32'hA, 12, pr, xr);
    check("R4 double press pulses", pr, 32'h28);
    check("R8 double press run", xr, 32'h70);
  endtask

  task automatic t_last_busy();
    logic [31:0] pr, xr;
    run_pat(32'h12, 12, pr, xr);
    check("R8 pulse in third cycle", pr, 32'h48);
    check("R8 run not extended", xr, 32'h70);
  endtask

  task automatic t_just_after();
    logic [31:0] pr, xr;
    run_pat(32'h22, 14, pr, xr);
    check("R9 pulse after idle", pr, 32'h88);
    check("R9 second run", xr, 32'h770);
  endtask

  task automatic t_mid_reset();
    button_i = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk); #1;
      if (k == 1) button_i = 1'b0;
    end
    check("R7 active before reset", {31'b0, active_o}, 32'h1);
    rst_ni = 1'b0;
    #0.5;
    check("R1 async reset clears active", {31'b0, active_o}, 32'h0);
    idle(2);
    check("R1 held reset press", {31'b0, press_o}, 32'h0);
    rst_ni = 1'b1;
    idle(4);
    check("R1 idle after reset", {30'b0, press_o, active_o}, 32'h0);
  endtask

  initial begin
    #1;
    t_reset();
    t_short_press();
    t_long_hold();
    t_double_press();
    t_last_busy();
    t_just_after();
    t_mid_reset();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule